// File: doc/BRIEF.md
# Sample Timing and Reset Controller

This block paces a multichannel converter front end from one master clock. It keeps a small set of control bits for the sample-rate select, the serial bit-clock rate and the operating mode. From these it produces a frame strobe once per sample period and a bit-clock enable that downstream shift logic uses to move serial data. It also brings out a mode flag, where 0 means program mode and 1 means data mode.

Two sources can start the same fixed-length reset sequence. One is a synchronous external reset pin. The other is a write of 1 to the software reset bit of the control register. During the sequence every control bit clears and both timing outputs stay quiet. When the sequence ends, a long settling delay runs before the first frame strobe. After that the strobe repeats once per selected sample period. A new rate that is written mid-frame only takes effect at the next frame boundary.

Top module: `smp_timing_ctl`

## Requirements
- R1: While rst_pin is high, and for the 4 cycles after the last clock edge at which it is sampled high, seq_busy_o is 1 and fs_o and bce_o are 0. In the cycle after that, seq_busy_o is 0.
- R2: A write to address 0 with wr_data[7]=1 starts the same 4-cycle sequence. The reset bit is not stored: seq_busy_o drops by itself 4 cycles after the write edge.
- R3: Either reset clears all control bits, so mode_o is 0, the rate code is 00 and the bit-clock code is 00.
- R4: Count the last edge of a reset trigger as edge 0. fs_o stays 0 up to edge 2069 and is first high in the cycle after edge 2070.
- R5: Address 1, wr_data[1:0] selects the sample period, measured between rising edges of fs_o: 00 gives 2048 cycles, 01 gives 1024, 10 gives 512 and 11 gives 256.
- R6: Address 1, wr_data[3:2] selects the bit period N: 00 gives 8 cycles, 01 gives 4, 10 gives 2 and 11 gives 1. bce_o pulses once every N cycles, with one pulse in the same cycle that fs_o rises, and fs_o stays high for exactly N cycles.
- R7: A change to either field of address 1 leaves the frame in progress at its old length and applies from the next frame boundary.
- R8: A write to address 0 with wr_data[7]=0 sets mode_o to wr_data[0] in the next cycle and starts no reset.
- R9: While a sequence runs, writes other than a software reset have no effect. Bits 6:1 at address 0 and bits 7:4 at address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_pin | input | 1 | Synchronous active-high external reset request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control (mode, software reset), 1 = rate (sample and bit-clock codes) |
| wr_data | input | 8 | Write data |
| fs_o | output | 1 | Frame strobe, one bit period wide, once per sample period |
| bce_o | output | 1 | Serial bit-clock enable |
| mode_o | output | 1 | 0 = program mode, 1 = data mode |
| seq_busy_o | output | 1 | Reset sequence in progress |

## Verification
The bench counts edges after each reset trigger and expects the first strobe on exactly edge 2070. An off-by-one in the load value of the delay counter moves that edge. It writes a new rate just after a frame starts and measures the current frame. A design that reloads on write would cut that frame short instead of keeping the old length. It also writes during an active reset sequence and then measures the default 2048/8 timing. A design that accepts the write would show the written timing. The fastest bit setting gives a one-cycle strobe and an enable that never drops, which catches bit counters that cannot wrap at a divide of one.

// File: rtl/smp_timing_pkg.sv
package smp_timing_pkg;

  localparam int DATA_W   = 8;
  localparam int RATE_W   = 2;
  localparam int BCK_W    = 2;
  localparam int MODE_BIT = 0;
  localparam int SRST_BIT = 7;
  localparam int RATE_LSB = 0;
  localparam int BCK_LSB  = 2;

  typedef enum logic { SEL_CTRL = 1'b0, SEL_RATE = 1'b1 } reg_sel_e;

  typedef struct packed {
    logic [BCK_W-1:0]  bck_code;
    logic [RATE_W-1:0] rate_code;
    logic              mode;
  } ctrl_t;

  // Sample period in clocks: code 0 is slowest, each step halves it.
  function automatic int unsigned frame_len(input logic [RATE_W-1:0] code,
                                            input int unsigned base);
    return base << (((1 << RATE_W) - 1) - int'(code));
  endfunction

  // Bit period in clocks: code 0 is slowest, each step halves it.
  function automatic int unsigned bit_div(input logic [BCK_W-1:0] code,
                                          input int unsigned slow);
    return slow >> int'(code);
  endfunction

endpackage

// File: rtl/smp_rst_seq.sv
module smp_rst_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_pin,
  input  logic sw_trig,
  output logic busy_now,
  output logic seq_busy
);
  localparam int W = $clog2(RST_CYCLES + 1);

  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst_pin || sw_trig)  left_q <= W'(RST_CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign seq_busy = (left_q != '0);
  assign busy_now = rst_pin | sw_trig | seq_busy;
endmodule

// File: rtl/smp_ctrl_regs.sv
module smp_ctrl_regs
  import smp_timing_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sw_trig,
  output ctrl_t             ctrl_q
);
  logic unused_bits;
  assign unused_bits = ^wr_data[6:4];

  assign sw_trig = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL) && wr_data[SRST_BIT];

  always_ff @(posedge clk) begin
    if (clr) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_CTRL: ctrl_q.mode <= wr_data[MODE_BIT];
        SEL_RATE: begin
          ctrl_q.rate_code <= wr_data[RATE_LSB +: RATE_W];
          ctrl_q.bck_code  <= wr_data[BCK_LSB +: BCK_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smp_frame_gen.sv
module smp_frame_gen
  import smp_timing_pkg::*;
#(
  parameter int BASE_PERIOD = 256,
  parameter int SLOW_DIV    = 8,
  parameter int FIRST_DELAY = 2070,
  parameter int RST_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              hold,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [BCK_W-1:0]  bck_code,
  output logic              fs_o,
  output logic              bce_o
);
  localparam int MAX_P      = BASE_PERIOD << ((1 << RATE_W) - 1);
  localparam int FIRST_LOAD = FIRST_DELAY - RST_CYCLES - 1;
  localparam int CNT_TOP    = (MAX_P > FIRST_LOAD) ? MAX_P : FIRST_LOAD;
  localparam int CNT_W      = $clog2(CNT_TOP + 1);
  localparam int BW         = $clog2(SLOW_DIV + 1);

  logic [CNT_W-1:0] fcnt_q, reload;
  logic [BW-1:0]    bcnt_q, div_act_q, div_new, div_sel, eff, bnext;
  logic             boundary, bce_now;

  always_comb begin
    boundary = (fcnt_q == '0);
    reload   = CNT_W'(frame_len(rate_code, BASE_PERIOD) - 1);
    div_new  = BW'(bit_div(bck_code, SLOW_DIV));
    div_sel  = boundary ? div_new : div_act_q;
    eff      = boundary ? '0 : bcnt_q;
    bce_now  = (eff == '0);
    bnext    = (eff == div_sel - 1'b1) ? '0 : eff + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      fcnt_q    <= CNT_W'(FIRST_LOAD);
      bcnt_q    <= '0;
      div_act_q <= BW'(SLOW_DIV);
      fs_o      <= 1'b0;
      bce_o     <= 1'b0;
    end else begin
      fcnt_q <= boundary ? reload : fcnt_q - 1'b1;
      bcnt_q <= bnext;
      if (boundary) div_act_q <= div_sel;
      bce_o  <= bce_now;
      if (boundary)     fs_o <= 1'b1;
      else if (bce_now) fs_o <= 1'b0;
    end
  end
endmodule

// File: rtl/smp_timing_ctl.sv
module smp_timing_ctl
  import smp_timing_pkg::*;
#(
  parameter int BASE_PERIOD  = 256,
  parameter int SLOW_BIT_DIV = 8,
  parameter int FIRST_DELAY  = 2070,
  parameter int RST_CYCLES   = 4
) (
  input  logic       clk,
  input  logic       rst_pin,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       fs_o,
  output logic       bce_o,
  output logic       mode_o,
  output logic       seq_busy_o
);
  logic  sw_trig, busy_now;
  ctrl_t ctrl_q;

  smp_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst_pin(rst_pin), .sw_trig(sw_trig),
    .busy_now(busy_now), .seq_busy(seq_busy_o)
  );

  smp_ctrl_regs u_regs (
    .clk(clk), .clr(busy_now), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_trig(sw_trig), .ctrl_q(ctrl_q)
  );

  smp_frame_gen #(
    .BASE_PERIOD(BASE_PERIOD), .SLOW_DIV(SLOW_BIT_DIV),
    .FIRST_DELAY(FIRST_DELAY), .RST_CYCLES(RST_CYCLES)
  ) u_frame (
    .clk(clk), .hold(busy_now), .rate_code(ctrl_q.rate_code),
    .bck_code(ctrl_q.bck_code), .fs_o(fs_o), .bce_o(bce_o)
  );

  assign mode_o = ctrl_q.mode;
endmodule

// File: rtl/smp_timing_ctl_chk.sv
module smp_timing_ctl_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_pin,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic       fs_o,
  input logic       bce_o,
  input logic       mode_o,
  input logic       seq_busy_o
);
  logic unused_chk;
  assign unused_chk = ^wr_data[6:1];

  logic sw_go;
  int   since_q;
  assign sw_go = wr_en && !wr_addr && wr_data[7];

  always_ff @(posedge clk) begin
    if (rst_pin || sw_go)         since_q <= 0;
    else if (since_q < RST_CYCLES) since_q <= since_q + 1;
  end

  p_quiet_in_seq_r1: assert property (@(posedge clk) disable iff (rst_pin)
    seq_busy_o |-> (!fs_o && !bce_o));

  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst_pin)
    seq_busy_o == (since_q < RST_CYCLES));

  p_sw_start_r2: assert property (@(posedge clk) disable iff (rst_pin)
    sw_go |=> seq_busy_o);

  p_mode_clear_r3: assert property (@(posedge clk) disable iff (rst_pin)
    seq_busy_o |-> !mode_o);

  p_fs_on_bce_r6: assert property (@(posedge clk) disable iff (rst_pin)
    $rose(fs_o) |-> bce_o);

  p_fs_drop_on_bce_r6: assert property (@(posedge clk) disable iff (rst_pin)
    ($fell(fs_o) && !seq_busy_o) |-> bce_o);

  p_mode_write_r8: assert property (@(posedge clk) disable iff (rst_pin)
    (wr_en && !wr_addr && !wr_data[7] && !seq_busy_o) |=> (mode_o == $past(wr_data[0])));
endmodule

bind smp_timing_ctl smp_timing_ctl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/tb_smp_timing_ctl.sv
module tb_smp_timing_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int FD = 2070;
  localparam int VN = 5;
  localparam int V_RATE [VN] = '{3, 2, 1, 0, 3};
  localparam int V_BCK  [VN] = '{3, 0, 2, 1, 1};
  localparam int V_P    [VN] = '{256, 512, 1024, 2048, 256};
  localparam int V_D    [VN] = '{1, 8, 2, 4, 4};

  logic clk = 1'b0;
  logic rst_pin = 1'b1;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic fs_o, bce_o, mode_o, seq_busy_o;

  int checks = 0, fails = 0;
  int win_len = 0, win_hi = 0, win_bce = 0;
  logic prev_fs = 1'b0;
  bit rose = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smp_timing_ctl dut (
    .clk(clk), .rst_pin(rst_pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fs_o(fs_o), .bce_o(bce_o), .mode_o(mode_o),
    .seq_busy_o(seq_busy_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task step();
    @(posedge clk); #1;
    win_len++;
    win_hi  += int'(fs_o);
    win_bce += int'(bce_o);
    rose    = fs_o && !prev_fs;
    prev_fs = fs_o;
  endtask

  task wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task wait_rise(output int len, output int hi, output int nb);
    int g;
    g = 0;
    do begin step(); g++; end while (!rose && g < 10000);
    len = win_len; hi = win_hi; nb = win_bce;
    win_len = 0; win_hi = 0; win_bce = 0;
  endtask

  task summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4 watchdog: actual 150000 cycles expected fewer");
      summary();
      $finish;
    end
  end

  initial begin
    int len, hi, nb, fs_seen, old_p;
    // R1: reset state while the pin is held
    repeat (3) step();
    chk("R1 busy during pin", int'(seq_busy_o), 1);
    chk("R1 fs during pin", int'(fs_o), 0);
    chk("R1 bce during pin", int'(bce_o), 0);
    chk("R3 mode after pin", int'(mode_o), 0);

    // R1/R4: release and count edges to the first strobe
    rst_pin = 1'b0;
    fs_seen = 0;
    for (int k = 1; k <= FD; k++) begin
      step();
      if (k == 3) begin
        chk("R1 busy tail", int'(seq_busy_o), 1);
        chk("R1 bce quiet in tail", int'(bce_o), 0);
      end
      if (k == 4) chk("R1 busy end", int'(seq_busy_o), 0);
      if (k < FD) fs_seen += int'(fs_o);
    end
    chk("R4 no early strobe after pin", fs_seen, 0);
    chk("R4 first strobe after pin", int'(fs_o), 1);
    win_len = 0; win_hi = 0; win_bce = 0;

    // R3/R5/R6: defaults give 2048-cycle frame, bit period 8
    wait_rise(len, hi, nb);
    chk("R3 R5 default period", len, 2048);
    chk("R3 R6 default strobe width", hi, 8);
    chk("R6 default enables per frame", nb, 256);

    // R8/R9: mode writes
    wr(1'b0, 8'h01);
    chk("R8 mode set", int'(mode_o), 1);
    wr(1'b0, 8'h7E);
    chk("R8 mode cleared", int'(mode_o), 0);
    chk("R9 no reset without bit 7", int'(seq_busy_o), 0);
    wr(1'b0, 8'h7F);
    chk("R9 reserved control bits", int'(mode_o), 1);

    // Vector table: rate/bit settings, each with a mid-stream change
    old_p = 2048;
    for (int v = 0; v < VN; v++) begin
      wait_rise(len, hi, nb);
      wr(1'b1, 8'hF0 | 8'(V_BCK[v] << 2) | 8'(V_RATE[v]));
      wait_rise(len, hi, nb);
      chk($sformatf("R7 frame kept v%0d", v), len, old_p);
      wait_rise(len, hi, nb);
      chk($sformatf("R5 R9 period v%0d", v), len, V_P[v]);
      chk($sformatf("R6 strobe width v%0d", v), hi, V_D[v]);
      chk($sformatf("R6 enables v%0d", v), nb, V_P[v] / V_D[v]);
      old_p = V_P[v];
    end
    chk("R8 mode kept over rate writes", int'(mode_o), 1);

    // R2: software reset, with a write inside the sequence
    wr(1'b0, 8'h81);
    chk("R2 busy after sw write", int'(seq_busy_o), 1);
    chk("R3 mode after sw reset", int'(mode_o), 0);
    fs_seen = 0;
    for (int k = 1; k <= FD; k++) begin
      if (k == 1) wr(1'b1, 8'h0F);
      else if (k == 2) wr(1'b0, 8'h01);
      else step();
      if (k == 2) chk("R9 mode write ignored in sequence", int'(mode_o), 0);
      if (k == 3) chk("R2 busy tail", int'(seq_busy_o), 1);
      if (k == 4) chk("R2 bit self-clears", int'(seq_busy_o), 0);
      if (k < FD) fs_seen += int'(fs_o);
    end
    chk("R4 no early strobe after sw", fs_seen, 0);
    chk("R2 R4 first strobe after sw", int'(fs_o), 1);
    win_len = 0; win_hi = 0; win_bce = 0;
    wait_rise(len, hi, nb);
    chk("R3 R9 period after sw reset", len, 2048);
    chk("R3 R9 width after sw reset", hi, 8);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule